// File: doc/BRIEF.md
# UART Interrupt Cause Identifier

This block gathers the interrupt sources of a UART and reports which one the CPU should service first. The sources are receiver line errors, received data ready, receive character timeout, transmit holding register empty and modem status changes. Each source is gated by its bit in an interrupt enable register. The block then picks the most urgent enabled cause under a fixed four-level priority. It presents that cause as an 8-bit identification value and as a registered interrupt request line.

Two pieces of source state live inside the block. The receive character timeout is measured from a one-per-character-time tick that the baud logic supplies. The transmit-empty cause is latched on the empty edge of the holding register. The bus decoder pulses `iir_rd_i` when software reads the identification value. If the cause shown at that moment is transmit-empty, the read acknowledges and clears it.

Top module: `uart_irq_ident`

## Requirements
- R1: After synchronous reset, `iir_o` is 8'h01 and `irq_o` is 0.
- R2: Enable bit 0 gates received-data and timeout, bit 1 gates transmit-empty, bit 2 gates line errors and bit 3 gates modem deltas. Bits 7..4 of `ier_i` have no effect on the outputs.
- R3: Under a fixed priority, `iir_o[2:1]` reports the highest enabled pending cause: 2'b11 line error (highest), 2'b10 received data or timeout, 2'b01 transmit-empty, 2'b00 modem status (lowest).
- R4: `iir_o[0]` is 0 while any enabled cause is pending and 1 when none is. `irq_o` is always its inverse.
- R5: When the reported cause is a receive timeout and `rx_avail_i` is low, `iir_o[3]` is 1 (code 4'hC). In every other case `iir_o[3]` is 0.
- R6: `iir_o[7:6]` is 2'b11 when `fifo_en_i` is high and 2'b00 when it is low. `iir_o[5:4]` is always 0.
- R7: Any single set bit of `lsr_err_i` (overrun, parity, framing, break) raises the line-error cause. Any set bit of `msr_delta_i` raises the modem cause.
- R8: The timeout flag sets once TO_CHARS `char_tick_i` pulses have been counted with `rx_nonempty_i` high and no `rx_read_i` or `rx_new_char_i`. Any of those three events clears the count and the flag in the following cycle.
- R9: The transmit-empty cause latches one cycle after `thr_empty_i` rises, where reset counts as low. It is cleared by `thr_write_i`, or by `iir_rd_i` while `iir_o[3:0]` is 4'h2. A rise in the same cycle wins over a clear.
- R10: `iir_o` and `irq_o` are registered. They reflect the inputs and internal source state of the previous cycle, so clearing an enable bit removes its cause one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 8 | Interrupt enable register value |
| lsr_err_i | input | LSR_W | Line error flags: overrun, parity, framing, break |
| rx_avail_i | input | 1 | Received data available (trigger level reached) |
| rx_nonempty_i | input | 1 | Receive FIFO holds at least one character |
| rx_new_char_i | input | 1 | A character was just written into the receive FIFO |
| rx_read_i | input | 1 | CPU read of the receive buffer |
| char_tick_i | input | 1 | One pulse per character time |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| thr_write_i | input | 1 | CPU write of the transmit holding register |
| msr_delta_i | input | MSR_W | Modem status change flags |
| fifo_en_i | input | 1 | FIFO mode enabled |
| iir_rd_i | input | 1 | CPU read strobe of the identification value |
| iir_o | output | 8 | Identification value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with TO_CHARS = 3 and keeps the four-bit widths of the error and modem flags. The short timeout lets random tick streams reach the timeout flag often. The timeout then races against reads, new characters and higher-priority line errors, so the 4'hC code and its clearing show up many times in one run. Directed sequences add the transmit-empty acknowledge on read, masking through the upper enable bits and each single error bit on its own.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  // cause codes for identification bits 3..1
  localparam logic [2:0] CAUSE_LINE = 3'b011;
  localparam logic [2:0] CAUSE_RXD  = 3'b010;
  localparam logic [2:0] CAUSE_RXTO = 3'b110;
  localparam logic [2:0] CAUSE_TXE  = 3'b001;
  localparam logic [2:0] CAUSE_MDM  = 3'b000;

  // enable register bit positions
  localparam int EN_RXD  = 0;
  localparam int EN_TXE  = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  localparam logic [7:0] IIR_IDLE = 8'h01;
endpackage

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
  parameter int TO_CHARS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic nonempty_i,
  input  logic new_char_i,
  input  logic read_i,
  input  logic tick_i,
  output logic timeout_o
);
  localparam int CW = $clog2(TO_CHARS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);

  logic [CW-1:0] cnt_q;
  logic          restart;

  assign restart = !nonempty_i || new_char_i || read_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = (cnt_q == LIMIT);

  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> !timeout_o);
  assert_last_tick_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (!restart && tick_i && cnt_q == LIMIT - 1'b1) |=> timeout_o);
endmodule

// File: rtl/uirq_txe_src.sv
module uirq_txe_src (
  input  logic clk,
  input  logic rst,
  input  logic empty_i,
  input  logic write_i,
  input  logic ack_i,
  output logic pend_o
);
  logic empty_q;
  logic rise;

  assign rise = empty_i && !empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      empty_q <= empty_i;
      if (rise)
        pend_o <= 1'b1;
      else if (write_i || ack_i)
        pend_o <= 1'b0;
    end
  end

  assert_rise_sets_R9: assert property (@(posedge clk) disable iff (rst)
    rise |=> pend_o);
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (!rise && (ack_i || write_i)) |=> !pend_o);
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
  import uirq_pkg::*;
#(
  parameter int LSR_W = 4,
  parameter int MSR_W = 4
) (
  input  logic [7:0]       ier_i,
  input  logic [LSR_W-1:0] lsr_err_i,
  input  logic             rx_avail_i,
  input  logic             timeout_i,
  input  logic             txe_pend_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  input  logic             fifo_en_i,
  output logic [7:0]       iir_next_o,
  output logic             irq_next_o
);
  logic       line_on, rxd_on, rxto_on, txe_on, mdm_on;
  logic [2:0] cause;
  logic       pending;

  assign line_on = ier_i[EN_LINE] && (|lsr_err_i);
  assign rxd_on  = ier_i[EN_RXD]  && rx_avail_i;
  assign rxto_on = ier_i[EN_RXD]  && timeout_i;
  assign txe_on  = ier_i[EN_TXE]  && txe_pend_i;
  assign mdm_on  = ier_i[EN_MDM]  && (|msr_delta_i);

  always_comb begin
    pending = 1'b1;
    if (line_on)      cause = CAUSE_LINE;
    else if (rxd_on)  cause = CAUSE_RXD;
    else if (rxto_on) cause = CAUSE_RXTO;
    else if (txe_on)  cause = CAUSE_TXE;
    else if (mdm_on)  cause = CAUSE_MDM;
    else begin
      cause   = CAUSE_MDM;
      pending = 1'b0;
    end
  end

  assign iir_next_o = {{2{fifo_en_i}}, 2'b00, cause, !pending};
  assign irq_next_o = pending;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter int TO_CHARS = 4,
  parameter int LSR_W    = 4,
  parameter int MSR_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       ier_i,
  input  logic [LSR_W-1:0] lsr_err_i,
  input  logic             rx_avail_i,
  input  logic             rx_nonempty_i,
  input  logic             rx_new_char_i,
  input  logic             rx_read_i,
  input  logic             char_tick_i,
  input  logic             thr_empty_i,
  input  logic             thr_write_i,
  input  logic [MSR_W-1:0] msr_delta_i,
  input  logic             fifo_en_i,
  input  logic             iir_rd_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic       timeout;
  logic       txe_pend;
  logic       txe_ack;
  logic [7:0] iir_next;
  logic       irq_next;

  // a read acknowledges transmit-empty only when that is the cause shown
  assign txe_ack = iir_rd_i && (iir_o[3:0] == {CAUSE_TXE, 1'b0});

  uirq_rx_timeout #(.TO_CHARS(TO_CHARS)) u_tmo (
    .clk        (clk),
    .rst        (rst),
    .nonempty_i (rx_nonempty_i),
    .new_char_i (rx_new_char_i),
    .read_i     (rx_read_i),
    .tick_i     (char_tick_i),
    .timeout_o  (timeout)
  );

  uirq_txe_src u_txe (
    .clk     (clk),
    .rst     (rst),
    .empty_i (thr_empty_i),
    .write_i (thr_write_i),
    .ack_i   (txe_ack),
    .pend_o  (txe_pend)
  );

  uirq_prio_enc #(.LSR_W(LSR_W), .MSR_W(MSR_W)) u_enc (
    .ier_i       (ier_i),
    .lsr_err_i   (lsr_err_i),
    .rx_avail_i  (rx_avail_i),
    .timeout_i   (timeout),
    .txe_pend_i  (txe_pend),
    .msr_delta_i (msr_delta_i),
    .fifo_en_i   (fifo_en_i),
    .iir_next_o  (iir_next),
    .irq_next_o  (irq_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_o <= IIR_IDLE;
      irq_o <= 1'b0;
    end else begin
      iir_o <= iir_next;
      irq_o <= irq_next;
    end
  end

  assert_line_first_R3: assert property (@(posedge clk) disable iff (rst)
    (ier_i[EN_LINE] && (|lsr_err_i)) |=> (iir_o[3:0] == 4'h6));
  assert_modem_raises_R4: assert property (@(posedge clk) disable iff (rst)
    (ier_i[EN_MDM] && (|msr_delta_i)) |=> irq_o);
  assert_all_off_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (ier_i[3:0] == 4'h0) |=> (!irq_o && iir_o[0]));
  assert_fifo_marks_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_en_i |=> (iir_o[7:6] == 2'b11));
endmodule

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  localparam int TO = 3;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] ier;
  logic [3:0] lsr, msr;
  logic       rx_avail, nonempty, new_char, rd_rx, tick;
  logic       thr_empty, thr_wr, fifo_en, iir_rd;
  logic [7:0] iir;
  logic       irq;

  int total = 0;
  int bad   = 0;

  // bench model state
  logic [7:0] exp_iir;
  logic       m_txe, m_empq;
  int         m_cnt;

  always #2.5 clk = ~clk;

  uart_irq_ident #(.TO_CHARS(TO), .LSR_W(4), .MSR_W(4)) dut (
    .clk(clk), .rst(rst), .ier_i(ier), .lsr_err_i(lsr), .rx_avail_i(rx_avail),
    .rx_nonempty_i(nonempty), .rx_new_char_i(new_char), .rx_read_i(rd_rx),
    .char_tick_i(tick), .thr_empty_i(thr_empty), .thr_write_i(thr_wr),
    .msr_delta_i(msr), .fifo_en_i(fifo_en), .iir_rd_i(iir_rd),
    .iir_o(iir), .irq_o(irq)
  );

  function automatic logic [7:0] expect_iir();
    logic [3:0] low;
    if (ier[2] && lsr != 0)                 low = 4'h6;
    else if (ier[0] && rx_avail)            low = 4'h4;
    else if (ier[0] && m_cnt == TO)         low = 4'hC;
    else if (ier[1] && m_txe)               low = 4'h2;
    else if (ier[3] && msr != 0)            low = 4'h0;
    else                                    low = 4'h1;
    return {{2{fifo_en}}, 2'b00, low};
  endfunction

  task automatic check(string tag);
    total++;
    if (iir !== exp_iir) begin
      bad++;
      $display("FAIL %s iir actual=%h expected=%h", tag, iir, exp_iir);
    end
    total++;
    if (irq !== !exp_iir[0]) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, !exp_iir[0]);
    end
  endtask

  // one clock: model update from current inputs, then compare
  task automatic step(string tag);
    logic [7:0] nxt;
    nxt = expect_iir();
    if (thr_empty && !m_empq)                        m_txe = 1'b1;
    else if (thr_wr || (iir_rd && exp_iir[3:0] == 4'h2)) m_txe = 1'b0;
    m_empq = thr_empty;
    if (!nonempty || new_char || rd_rx) m_cnt = 0;
    else if (tick && m_cnt != TO)       m_cnt = m_cnt + 1;
    exp_iir = nxt;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic quiet();
    ier = 8'h00; lsr = 0; msr = 0; rx_avail = 0; nonempty = 0; new_char = 0;
    rd_rx = 0; tick = 0; thr_empty = 0; thr_wr = 0; fifo_en = 0; iir_rd = 0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    quiet();
    rst = 1'b1;
    exp_iir = 8'h01; m_txe = 0; m_empq = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1");

    // R2: upper enable bits mask nothing in, lower bits map per source
    ier = 8'hF0; lsr = 4'hF; msr = 4'hF; rx_avail = 1;
    step("R2"); step("R2");
    ier = 8'h08; step("R2");
    ier = 8'h01; step("R2");

    // R7: each error bit alone raises the line cause
    ier = 8'h0F;
    for (int b = 0; b < 4; b++) begin
      lsr = 4'(1 << b); step("R7");
    end
    for (int b = 0; b < 4; b++) begin
      lsr = 0; rx_avail = 0; msr = 4'(1 << b); step("R7");
    end

    // R3: strip sources from top priority downward
    lsr = 4'h2; rx_avail = 1; msr = 4'h1; step("R3");
    lsr = 0; step("R3");
    rx_avail = 0; step("R3");
    msr = 0; step("R4");

    // R8/R5: timeout with TO ticks, then cleared by a read
    nonempty = 1; tick = 1;
    for (int i = 0; i < TO + 2; i++) step("R8");
    tick = 0; step("R5");
    rx_avail = 1; step("R5");
    rx_avail = 0; rd_rx = 1; step("R8");
    rd_rx = 0; step("R8");
    nonempty = 0; step("R8");

    // R9: transmit-empty edge, acknowledge by identification read
    ier = 8'h02; thr_empty = 1; step("R9"); step("R9");
    iir_rd = 1; step("R9");
    iir_rd = 0; step("R9");
    thr_empty = 0; thr_wr = 1; step("R9");
    thr_wr = 0; thr_empty = 1; step("R9"); step("R9");
    thr_wr = 1; step("R9");
    thr_wr = 0; step("R9");

    // R6: FIFO marker bits
    fifo_en = 1; step("R6");
    fifo_en = 0; step("R6");

    // R10: dropping an enable removes the cause one cycle later
    ier = 8'h08; msr = 4'h4; step("R10");
    ier = 8'h00; step("R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      ier       = 8'($urandom);
      lsr       = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
      msr       = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      rx_avail  = ($urandom % 5 == 0);
      nonempty  = ($urandom % 8 != 0);
      new_char  = ($urandom % 10 == 0);
      rd_rx     = ($urandom % 10 == 0);
      tick      = ($urandom % 2 == 0);
      thr_empty = ($urandom % 3 != 0);
      thr_wr    = ($urandom % 8 == 0);
      fifo_en   = ($urandom % 2 == 0);
      iir_rd    = ($urandom % 3 == 0);
      step("R10");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule